// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words by 16 bits. The RAM has active-low chip, output and write enables and one active-low select per byte lane. The host presents a request carrying an address, a write flag, write data and a per-lane byte enable. The controller sequences the RAM strobes over a whole number of clock cycles per phase, controls the direction of the shared data bus, and returns read data with a one-cycle done pulse.

Each phase length is the ceiling of a nanosecond timing figure divided by a clock-period parameter, never less than one cycle. A read holds the chip and output enables low for the longest of the address-access, read-cycle and output-enable-access figures, and captures data on its last cycle. A write holds the chip, write and lane selects low together, so the write window is their overlap and all of them end on the same edge. Write data is driven over the whole window and for at least one recovery cycle after it, which covers data setup and hold against that edge. A write that follows a read gets one extra turnaround cycle before the bus is driven.

The request side is valid/ready. `req_ready` is high only while the controller is idle, and a request transfers on a cycle where `req_valid` and `req_ready` are both high. The host must hold its request fields steady while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `rsp_valid` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and all `mem_bsel_n` bits are 1, and `mem_dq_oe` is 0.
- R2: `req_ready` is 1 exactly when the controller is idle. It falls in the cycle after a request transfers and stays 0 until the cycle after the `rsp_valid` pulse.
- R3: A read with a nonzero byte enable holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles, where RD is the largest of ceil(tAA/T), ceil(tRC/T) and ceil(tDOE/T). During those cycles `mem_addr` equals the request address and `mem_bsel_n` equals the inverted byte enable. Bit 1 is the upper lane (data 15:8) and bit 0 is the lower lane (data 7:0).
- R4: Read data is sampled from `mem_dq_i` on the last access cycle and `rsp_valid` is 1 in the following cycle. In `rsp_rdata`, lanes whose enable bit was 0 read as 0x00.
- R5: A write with a nonzero byte enable holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_bsel_n` = inverted byte enable for PW cycles, where PW = max(ceil(tPWE/T), ceil(tSD/T)). Throughout that window `mem_dq_oe`=1 and `mem_dq_o` equals the write data.
- R6: After the write strobes rise, `mem_dq_oe`, `mem_dq_o` and `mem_addr` stay unchanged for REC = max(1, ceil(tWC/T) − PW) cycles. `rsp_valid` follows in the next cycle.
- R7: When a write with a nonzero enable follows a read with a nonzero enable, one cycle with every strobe high and `mem_dq_oe`=0 lies between the transfer and the first write-strobe cycle. Otherwise the write strobes start in the first cycle after the transfer.
- R8: `mem_dq_oe` is 1 only during a write's strobe and recovery cycles, and it is never 1 while `mem_oe_n` is 0.
- R9: A request whose byte enable is 0b00 asserts no strobe, and its `rsp_valid` comes in the first cycle after the transfer.
- R10: `rsp_valid` lasts exactly one cycle. For writes and zero-enable requests, `rsp_rdata` is 0 during the pulse.
- R11: `mem_oe_n` and `mem_we_n` are never both 0. Whenever `mem_we_n` is 0, `mem_ce_n` is 0 and at least one `mem_bsel_n` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, masked per lane |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_bsel_n | output | 2 | RAM lane selects, active low, bit 1 upper |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from the RAM pads |

## Verification
Some rules can be checked on every cycle without regard to the request stream. The assertions cover these: output and write enables never overlap, the bus is never driven against the RAM's outputs, every write-enable cycle also has chip enable and a lane select low, write data and address hold across the write-ending edge, the done pulse lasts one cycle, and a zero-enable request completes at once. Other properties depend on the request stream and on what the RAM holds. Only the bench scenarios show these: the exact phase lengths, the turnaround cycle that appears only after a read, the per-lane merge of partial writes seen through later reads, and the zeroing of unselected lanes in read data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_DONE
  } ctl_state_t;

  // Whole clock cycles covering a nanosecond figure, never fewer than one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     cap,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lane_q <= '0;
      else if (clr) lane_q <= '0;
      else if (cap) lane_q <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
    assign dout[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LANES         = 2,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_DOE_NS      = 5,
  parameter int T_WC_NS       = 10,
  parameter int T_PWE_NS      = 8,
  parameter int T_SD_NS       = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_be,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [LANES-1:0]        mem_bsel_n,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_i
);

  localparam int DATA_W  = LANES * LANE_W;
  localparam int RD_CYC  = imax(imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_RC_NS, CLK_PERIOD_NS)),
                                ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS));
  localparam int PW_CYC  = imax(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_SD_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - PW_CYC);
  localparam int MAX_CYC = imax(RD_CYC, imax(PW_CYC, REC_CYC));
  localparam int CW      = imax(1, $clog2(MAX_CYC + 1));
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] PW_LD  = CW'(PW_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  ctl_state_t          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q;
  logic                last_rd_q;
  logic                accept;
  logic                tmr_load;
  logic [CW-1:0]       tmr_val;
  logic                tmr_exp;
  logic                rd_cap;
  logic                strobe_on;

  assign accept = req_valid && (state_q == ST_IDLE);

  // Next state and phase-timer loading
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_be == '0) begin
            state_d = ST_DONE;
          end else if (!req_write) begin
            state_d  = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end else if (last_rd_q) begin
            state_d = ST_WR_TURN;
          end else begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = PW_LD;
          end
        end
      end
      ST_RD_ACC:   if (tmr_exp) state_d = ST_DONE;
      ST_WR_TURN: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = PW_LD;
      end
      ST_WR_PULSE: begin
        if (tmr_exp) begin
          state_d  = ST_WR_RECOV;
          tmr_load = 1'b1;
          tmr_val  = REC_LD;
        end
      end
      ST_WR_RECOV: if (tmr_exp) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (state_q == ST_RD_ACC && tmr_exp)   last_rd_q <= 1'b1;
      if (state_q == ST_WR_RECOV && tmr_exp) last_rd_q <= 1'b0;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign rd_cap = (state_q == ST_RD_ACC) && tmr_exp;

  sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .cap     (rd_cap),
    .lane_en (be_q),
    .din     (mem_dq_i),
    .dout    (rsp_rdata)
  );

  // Strobe and bus-direction decode from the registered state
  assign strobe_on  = (state_q == ST_RD_ACC) || (state_q == ST_WR_PULSE);
  assign mem_ce_n   = !strobe_on;
  assign mem_oe_n   = (state_q != ST_RD_ACC);
  assign mem_we_n   = (state_q != ST_WR_PULSE);
  assign mem_bsel_n = strobe_on ? ~be_q : '1;
  assign mem_dq_oe  = (state_q == ST_WR_PULSE) || (state_q == ST_WR_RECOV);
  assign mem_dq_o   = wdata_q;
  assign mem_addr   = addr_q;
  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_DONE);

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [LANES-1:0]        req_be,
  input logic                    rsp_valid,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    mem_ce_n,
  input logic                    mem_oe_n,
  input logic                    mem_we_n,
  input logic [LANES-1:0]        mem_bsel_n,
  input logic [LANES*LANE_W-1:0] mem_dq_o,
  input logic                    mem_dq_oe
);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  p_write_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe && ($countones(mem_bsel_n) < LANES)));

  p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

  p_no_bus_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_zero_be_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_be == '0)) |=> (rsp_valid && mem_ce_n));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_oe_we_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .LANE_W (LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_be     (req_be),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bsel_n (mem_bsel_n),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

  // Timing chosen to give multi-cycle phases: T = 3 ns
  // RD = max(ceil(10/3), ceil(10/3), ceil(5/3)) = 4
  // PW = max(ceil(8/3), ceil(6/3)) = 3, REC = max(1, ceil(10/3) - 3) = 1
  localparam int EXP_RD  = 4;
  localparam int EXP_PW  = 3;
  localparam int EXP_REC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_bsel_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int checks = 0;
  int fails  = 0;
  bit last_was_rd = 1'b0;

  logic [15:0] ram     [0:255];
  logic [15:0] ref_mem [0:255];

  always #10 clk = ~clk;

  sram_lane_ctrl #(.CLK_PERIOD_NS(3)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_bsel_n (mem_bsel_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_i   (mem_dq_i)
  );

  // RAM model: unselected lanes return a filler pattern
  always_comb begin
    mem_dq_i[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bsel_n[1]) ? ram[mem_addr[7:0]][15:8] : 8'h5A;
    mem_dq_i[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bsel_n[0]) ? ram[mem_addr[7:0]][7:0]  : 8'h5A;
  end

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_bsel_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
      if (!mem_bsel_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    int n = 0, we_low = 0, oe_low = 0, rec = 0, first_we = 0, lat;
    int lane_bad = 0, strobe_seen = 0, ready_bad = 0, bus_bad = 0;
    bit turn;
    logic [15:0] exp_rd;
    turn = w && (be != 2'b00) && last_was_rd;
    if (w || be == 2'b00) exp_rd = 16'h0000;
    else exp_rd = {be[1] ? ref_mem[a[7:0]][15:8] : 8'h00, be[0] ? ref_mem[a[7:0]][7:0] : 8'h00};
    if (be == 2'b00) lat = 1;
    else if (w)      lat = (turn ? 1 : 0) + EXP_PW + EXP_REC + 1;
    else             lat = EXP_RD + 1;

    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (req_ready) ready_bad++;
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_bsel_n != 2'b11) strobe_seen++;
      if (!mem_we_n) begin
        we_low++;
        if (first_we == 0) first_we = n;
        if (mem_bsel_n != ~be || mem_dq_o != d || mem_addr != a) lane_bad++;
      end
      if (!mem_oe_n) begin
        oe_low++;
        if (mem_bsel_n != ~be || mem_addr != a || mem_ce_n) lane_bad++;
      end
      if (mem_dq_oe && mem_we_n) begin
        rec++;
        if (mem_dq_o != d || mem_addr != a) lane_bad++;
      end
      if (mem_dq_oe && (!w || !mem_oe_n)) bus_bad++;
    end while (!rsp_valid && n < 40);

    chk(n == lat, "R2 latency to done", n, lat);
    chk(ready_bad == 0, "R2 ready low while busy", ready_bad, 0);
    chk(rsp_rdata == exp_rd, w ? "R10 write rdata zero" : "R4 read data", rsp_rdata, exp_rd);
    chk(bus_bad == 0, "R8 bus drive only in write", bus_bad, 0);
    if (be == 2'b00) begin
      chk(strobe_seen == 0, "R9 zero enable no strobe", strobe_seen, 0);
    end else if (w) begin
      chk(we_low == EXP_PW, "R5 write pulse length", we_low, EXP_PW);
      chk(rec == EXP_REC, "R6 recovery hold length", rec, EXP_REC);
      chk(first_we == (turn ? 2 : 1), "R7 turnaround placement", first_we, turn ? 2 : 1);
      chk(lane_bad == 0, "R5 write lanes and data", lane_bad, 0);
    end else begin
      chk(oe_low == EXP_RD, "R3 read access length", oe_low, EXP_RD);
      chk(lane_bad == 0, "R3 read lanes and address", lane_bad, 0);
    end
    @(negedge clk);
    chk(!rsp_valid, "R10 done single cycle", rsp_valid, 0);
    chk(req_ready, "R2 ready back after done", req_ready, 1);

    if (be != 2'b00) begin
      if (w) begin
        if (be[1]) ref_mem[a[7:0]][15:8] = d[15:8];
        if (be[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
      end
      last_was_rd = !w;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 256; i++) begin
      ram[i]     = 16'(i * 16'h0101) ^ 16'h3C3C;
      ref_mem[i] = 16'(i * 16'h0101) ^ 16'h3C3C;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_bsel_n == 2'b11 && !mem_dq_oe,
        "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe}, 6'b111110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 after release", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    // Directed corner cases
    run_op(1'b1, 16'h0010, 16'hBEEF, 2'b11);  // R5 full write, no turnaround
    run_op(1'b0, 16'h0010, 16'h0000, 2'b11);  // R3 R4 full read
    run_op(1'b1, 16'h0010, 16'h1234, 2'b10);  // R7 write after read, upper only
    run_op(1'b1, 16'h0010, 16'h5678, 2'b01);  // write after write, lower only
    run_op(1'b0, 16'h0010, 16'h0000, 2'b10);  // R4 lower lane masked
    run_op(1'b1, 16'h0010, 16'hFFFF, 2'b00);  // R9 zero-enable write
    run_op(1'b0, 16'h0010, 16'h0000, 2'b00);  // R9 zero-enable read
    run_op(1'b1, 16'h0020, 16'hA1B2, 2'b11);  // R7 turnaround survives zero-enable ops
    run_op(1'b0, 16'h0010, 16'h0000, 2'b01);  // R4 upper lane masked
    run_op(1'b0, 16'hFF0F, 16'h0000, 2'b11);  // top address bits

    // Constrained random mix
    for (int k = 0; k < 120; k++) begin
      logic [15:0] ra;
      ra = {8'($urandom), 4'h0, 4'($urandom)};
      run_op(1'($urandom), ra, 16'($urandom), 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule